// File: doc/BRIEF.md
# Indirect Pattern RAM Access Controller

This block sits between a 16-bit synchronous register bus and a 128-word by 40-bit pattern RAM. Software reaches the RAM only indirectly, through three registers: a control register and two data registers, called A and B. A control write carries a mode bit. When that bit is 0, the write also selects a RAM word, which can then be read back or rewritten through the data registers. A word is only written to the RAM after a strict sequence of three register writes. The 40-bit word is put together from the upper byte of the control write and the two 16-bit data writes.

Setting the mode bit puts the block in match mode. In match mode the host can no longer read or write the RAM. A separate valid/ready read port then lets the downstream matching engine fetch RAM words. The port takes a request in any cycle in which `m_req_valid` and `m_req_ready` are both high. `m_req_ready` is high exactly while match mode is on. The response comes back on the next cycle and cannot be back-pressured, so the consumer must accept it when it arrives.

Register select codes on `reg_sel`: 0 is the control register, 1 is data register A, 2 is data register B, and 3 is unmapped. Only one bus write or read is issued per cycle.

Top module: `patram_host_access`

## Requirements
- R1: After reset, `match_en`, `m_req_ready`, `reg_rvalid` and `m_rsp_valid` are 0, and `reg_rdata` is 0.
- R2: A control write with bit 7 set to 1 turns match mode on. A control write with bit 7 set to 0 turns it off. `match_en` shows the new mode one cycle after the write and does not change without a control write.
- R3: While match mode is on, writes to data registers A and B, and bits other than bit 7 of a control write with bit 7 set to 1, have no effect. The RAM and the write sequence are left untouched.
- R4: While match mode is on, a read of the control register returns 0x0080, and a read of A, B or select 3 returns 0.
- R5: A control write with bit 7 set to 0 latches bits 6:0 as the word address. A control readback then has bits 6:0 equal to that address and bit 7 equal to 0.
- R6: In host mode, a read gives `reg_rvalid` one cycle later. The three registers may be read in any order, with this layout: control bits 15:8 = word bits 7:0, A = word bits 23:8, B = word bits 39:24. Reads must be issued at least three cycles after the address write or after a commit.
- R7: The sequence control write (bit 7 = 0), then write to A, then write to B stores one 40-bit word at the latched address. The word is made of: control bits 15:8 as word bits 7:0, A as bits 23:8, and B as bits 39:24. Nothing is stored before the write to B.
- R8: A write to B that does not directly follow a sequenced write to A is dropped. This includes a second write to B after a commit.
- R9: A new control write restarts the sequence. A write to B that follows it without a new write to A is dropped.
- R10: In match mode, an accepted request on the read port returns the addressed word on `m_rsp_data`, with `m_rsp_valid` high for one cycle on the next cycle. In host mode no request is accepted.
- R11: After a commit, host readback shows the newly stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select (0 control, 1 A, 2 B) |
| reg_wdata | input | 16 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| reg_rdata | output | 16 | Read data |
| match_en | output | 1 | Match mode flag |
| m_req_valid | input | 1 | Match-side read request |
| m_req_ready | output | 1 | Request accepted when high with valid |
| m_req_addr | input | 7 | Match-side word address |
| m_rsp_valid | output | 1 | Match-side response strobe |
| m_rsp_data | output | 40 | Match-side word |

## Verification
The bench targets the write-order corner cases:
- A write to B with no write to A before it. A design that commits on any write to B would overwrite the word.
- A second write to B after a commit. A design that stays armed would store the new B data.
- A control write in the middle of a sequence. A design that keeps its sequence state would store a mixed word.

In match mode, the bench checks that data writes leave the RAM intact and that readback is masked. Leaky gating would expose the stored bytes or corrupt them. The bench also checks that the match port refuses requests in host mode. Finally, it reads the registers in scrambled orders to catch a swapped byte mapping.

// File: rtl/patram_pkg.sv
package patram_pkg;
  localparam int ADDR_W   = 7;
  localparam int WORD_W   = 40;
  localparam int REG_W    = 16;
  localparam int MODE_BIT = 7;
  localparam int DEPTH    = 1 << ADDR_W;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DA   = 2'd1,
    SEL_DB   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_ADDR = 2'd1,
    WS_AWR  = 2'd2
  } wseq_e;
endpackage

// File: rtl/patram_mem.sv
module patram_mem #(
  parameter int AW = 7,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  AST_ONE_OP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !re); // R7
endmodule

// File: rtl/patram_wseq.sv
module patram_wseq
  import patram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_host_wr,
  input  logic          ctrl_match_wr,
  input  logic          a_wr,
  input  logic          b_wr,
  input  logic [RW-1:0] wdata,
  output logic [AW-1:0] addr_q,
  output logic          commit,
  output logic [WW-1:0] commit_word
);
  localparam int B0_W = WW - 2 * RW;

  wseq_e st_q, st_d;
  logic [B0_W-1:0] b0_q;
  logic [RW-1:0]   a_q;

  always_comb begin
    st_d = st_q;
    if (ctrl_host_wr)       st_d = WS_ADDR;
    else if (ctrl_match_wr) st_d = WS_IDLE;
    else if (a_wr)          st_d = (st_q == WS_ADDR) ? WS_AWR : WS_IDLE;
    else if (b_wr)          st_d = WS_IDLE;
  end

  assign commit      = b_wr && (st_q == WS_AWR);
  assign commit_word = {wdata, a_q, b0_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      addr_q <= '0;
      b0_q   <= '0;
      a_q    <= '0;
    end else begin
      st_q <= st_d;
      if (ctrl_host_wr) begin
        addr_q <= wdata[AW-1:0];
        b0_q   <= wdata[RW-1 -: B0_W];
      end
      if (a_wr && st_q == WS_ADDR) a_q <= wdata;
    end
  end

  AST_COMMIT_CLOSES_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (st_q == WS_IDLE)); // R8
  AST_AWR_ONLY_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_AWR && $past(st_q) != WS_AWR) |-> ($past(st_q) == WS_ADDR)); // R9
endmodule

// File: rtl/patram_rdmux.sv
module patram_rdmux
  import patram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [1:0]    sel,
  input  logic          mode,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] word,
  output logic          rvalid,
  output logic [RW-1:0] rdata
);
  localparam int B0_W = WW - 2 * RW;

  logic [RW-1:0] mux_d;

  always_comb begin
    mux_d = '0;
    if (mode) begin
      if (reg_sel_e'(sel) == SEL_CTRL) mux_d[MODE_BIT] = 1'b1;
    end else begin
      unique case (reg_sel_e'(sel))
        SEL_CTRL: mux_d = {word[B0_W-1:0], 1'b0, addr};
        SEL_DA:   mux_d = word[B0_W +: RW];
        SEL_DB:   mux_d = word[B0_W + RW +: RW];
        default:  mux_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux_d;
    end
  end
endmodule

// File: rtl/patram_host_access.sv
module patram_host_access
  import patram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              reg_rvalid,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              match_en,
  input  logic              m_req_valid,
  output logic              m_req_ready,
  input  logic [ADDR_W-1:0] m_req_addr,
  output logic              m_rsp_valid,
  output logic [WORD_W-1:0] m_rsp_data
);
  logic mode_q;
  logic ctrl_wr, ctrl_host_wr, ctrl_match_wr, a_wr, b_wr;
  logic fetch_pend, fetch_done, m_accept;
  logic commit;
  logic [WORD_W-1:0] commit_word, ram_dout, word_q;
  logic [ADDR_W-1:0] seq_addr, ram_addr;

  assign ctrl_wr       = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
  assign ctrl_host_wr  = ctrl_wr && !reg_wdata[MODE_BIT];
  assign ctrl_match_wr = ctrl_wr && reg_wdata[MODE_BIT];
  assign a_wr          = reg_wr && (reg_sel_e'(reg_sel) == SEL_DA) && !mode_q;
  assign b_wr          = reg_wr && (reg_sel_e'(reg_sel) == SEL_DB) && !mode_q;

  assign match_en    = mode_q;
  assign m_req_ready = mode_q;
  assign m_accept    = m_req_valid && mode_q;
  assign ram_addr    = mode_q ? m_req_addr : seq_addr;
  assign m_rsp_data  = ram_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= 1'b0;
      fetch_pend  <= 1'b0;
      fetch_done  <= 1'b0;
      word_q      <= '0;
      m_rsp_valid <= 1'b0;
    end else begin
      if (ctrl_wr) mode_q <= reg_wdata[MODE_BIT];
      fetch_pend  <= ctrl_host_wr || commit;
      fetch_done  <= fetch_pend;
      if (fetch_done) word_q <= ram_dout;
      m_rsp_valid <= m_accept;
    end
  end

  patram_wseq #(.AW(ADDR_W), .WW(WORD_W), .RW(REG_W)) u_wseq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_host_wr (ctrl_host_wr),
    .ctrl_match_wr(ctrl_match_wr),
    .a_wr         (a_wr),
    .b_wr         (b_wr),
    .wdata        (reg_wdata),
    .addr_q       (seq_addr),
    .commit       (commit),
    .commit_word  (commit_word)
  );

  patram_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (commit),
    .re   (fetch_pend || m_accept),
    .addr (ram_addr),
    .wdata(commit_word),
    .rdata(ram_dout)
  );

  patram_rdmux #(.AW(ADDR_W), .WW(WORD_W), .RW(REG_W)) u_rdmux (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (reg_rd),
    .sel   (reg_sel),
    .mode  (mode_q),
    .addr  (seq_addr),
    .word  (word_q),
    .rvalid(reg_rvalid),
    .rdata (reg_rdata)
  );

  AST_NO_WRITE_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !match_en); // R3
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_wr) |-> $stable(match_en)); // R2
  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid && $past(match_en)) |-> ((reg_rdata & 16'hFF7F) == 16'h0000)); // R4
  AST_RSP_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid |-> $past(match_en)); // R10
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pend |-> !m_accept); // R10
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (match_en && $past(match_en)) |-> $stable(seq_addr)); // R3
endmodule

// File: tb/sim_patram_host_access.sv
`timescale 1ns/1ps
module sim_patram_host_access;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [15:0] reg_rdata;
  logic        match_en;
  logic        m_req_valid = 1'b0;
  logic        m_req_ready;
  logic [6:0]  m_req_addr = '0;
  logic        m_rsp_valid;
  logic [39:0] m_rsp_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  patram_host_access u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] sel, output logic [15:0] d, input string req);
    @(negedge clk); reg_rd = 1; reg_sel = sel;
    @(negedge clk); reg_rd = 0;
    chk(req, reg_rvalid, 1);
    d = reg_rdata;
  endtask

  task automatic expect_word(logic [6:0] a, logic [39:0] w, string req);
    logic [15:0] d;
    rd(2'd2, d, req); chk(req, d, w[39:24]);
    rd(2'd0, d, req); chk(req, d, {w[7:0], 1'b0, a});
    rd(2'd1, d, req); chk(req, d, w[23:8]);
  endtask

  task automatic mread(logic [6:0] a, logic [39:0] w, string req);
    @(negedge clk); m_req_valid = 1; m_req_addr = a;
    chk(req, m_req_ready, 1);
    @(negedge clk); m_req_valid = 0;
    chk(req, m_rsp_valid, 1);
    chk(req, m_rsp_data, w);
    @(negedge clk);
    chk(req, m_rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", match_en, 0);
    chk("R1", m_req_ready, 0);
    chk("R1", reg_rvalid, 0);
    chk("R1", m_rsp_valid, 0);
    chk("R1", reg_rdata, 0);
  endtask

  task automatic t_write_seq();
    wr(0, 16'hA505); wr(1, 16'h1234); wr(2, 16'hBEEF);
    expect_word(7'h05, 40'hBEEF_1234_A5, "R7_R11");
    wr(0, 16'h3C7F); wr(1, 16'h5678); wr(2, 16'h9ABC);
    expect_word(7'h7F, 40'h9ABC_5678_3C, "R5_R6");
    wr(0, 16'h0005);
    expect_word(7'h05, 40'hBEEF_1234_A5, "R6");
  endtask

  task automatic t_drop_b();
    wr(0, 16'h1105); wr(2, 16'h2222);
    expect_word(7'h05, 40'hBEEF_1234_A5, "R8");
    wr(0, 16'h2205); wr(1, 16'h3333); wr(2, 16'h4444); wr(2, 16'h5555);
    expect_word(7'h05, 40'h4444_3333_22, "R8");
  endtask

  task automatic t_restart();
    wr(0, 16'h9905); wr(1, 16'h6666); wr(0, 16'h7705); wr(2, 16'h8888);
    expect_word(7'h05, 40'h4444_3333_22, "R9");
  endtask

  task automatic t_match();
    logic [15:0] d;
    @(negedge clk); m_req_valid = 1; m_req_addr = 7'h05;
    chk("R10 host", m_req_ready, 0);
    @(negedge clk); m_req_valid = 0;
    chk("R10 host", m_rsp_valid, 0);
    wr(0, 16'h0080);
    chk("R2", match_en, 1);
    rd(0, d, "R4"); chk("R4", d, 16'h0080);
    rd(1, d, "R4"); chk("R4", d, 16'h0000);
    rd(2, d, "R4"); chk("R4", d, 16'h0000);
    wr(0, 16'hEE85); wr(1, 16'hDEAD); wr(2, 16'hF00D);
    chk("R3", match_en, 1);
    mread(7'h05, 40'h4444_3333_22, "R3_R10");
    mread(7'h7F, 40'h9ABC_5678_3C, "R10");
    wr(0, 16'h0005);
    chk("R2", match_en, 0);
    chk("R10", m_req_ready, 0);
    expect_word(7'h05, 40'h4444_3333_22, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_seq();
    t_drop_b();
    t_restart();
    t_match();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule